// File: doc/BRIEF.md
# Three-Level Offset PWM Modulator for an H-Bridge Loss Test

This block drives two three-level T-type phase legs that are wired as an H-bridge, with a load inductor connected between the two leg outputs. It is used in a constant-current loss test. One shared triangular carrier runs as an up/down counter. Each leg adds its own signed offset to a common sinusoidal modulation reference and saturates the sum. It then scales the result to carrier units and latches it once per carrier peak. The latched threshold is compared against two mirrored carriers, one spanning 0 to +1 and one spanning -1 to 0. The comparison gives a three-level phase state: positive, zero or negative.

Setting the two legs to slightly different offsets gives them different modulation degrees. The resulting voltage-time area across the inductor sets the circulating DC current. The offsets come from an external current controller, and this block only applies them. Each leg's phase state is decoded into four gate signals. The sequencer requires a new state to be requested for a full dead time before it acts on it. It then holds both devices of each complementary pair off for one dead time. It never passes directly between the positive and negative levels.

A synchronous enable shuts every gate off at once. After the enable returns, switching resumes only at a carrier valley.

Top module: `tlpwm_hbridge`

## Requirements
- R1: While reset is held, and after it until the enable has been seen high at a carrier valley, both gate outputs are 4'b0000.
- R2: The carrier counter rises by one per clock from 0 to P and falls back to 0, so one carrier period is 2P clocks. P is the period input, and a value below 2 is treated as 2.
- R3: The sum of the reference and a leg's offset (both signed Q1.15) is saturated to the range -32768..32767 before scaling, so a sum that overflows cannot change sign.
- R4: A leg's threshold T = floor(m*P/32768), where m is the saturated sum. T is latched only on the clock where the counter equals P. Reference and offset values present at any other clock have no effect.
- R5: With carrier count c, a leg requests the positive state when T > c, the negative state when T < -c, and the zero state otherwise.
- R6: Gate bits [3:0] are top outer, upper inner, lower inner and bottom outer. Positive is 4'b1100, zero is 4'b0110 and negative is 4'b0011.
- R7: On each committed change, the gates show the bitwise AND of the old and new patterns for exactly D clocks, then the new pattern. D is the dead input, and 0 is treated as 1.
- R8: A requested change is committed only after the same request has been seen for D consecutive clocks. A shorter request leaves the gates unchanged.
- R9: From the positive state, a negative request first moves the leg to zero, and the reverse works the same way. The outer devices of a leg are never on in consecutive clocks.
- R10: A clock edge that samples the enable low forces both gate outputs to 4'b0000 immediately after that edge, and both legs restart in the zero state.
- R11: After the enable returns high, gating resumes only after an edge where the enable is high and the counter is 0. The first pattern shown is the zero pattern.
- R12: Leg A uses off_a and leg B uses off_b. Opposite offsets with a zero reference make leg A switch only between zero and positive, and leg B only between zero and negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Synchronous enable; low forces all gates off |
| ref_in | input | DW | Signed Q1.15 modulation reference |
| off_a | input | DW | Signed Q1.15 offset for leg A |
| off_b | input | DW | Signed Q1.15 offset for leg B |
| period | input | CW | Half switching period in clocks |
| dead | input | DTW | Dead time in clocks |
| gate_a | output | 4 | Leg A gates {top outer, upper inner, lower inner, bottom outer} |
| gate_b | output | 4 | Leg B gates, same order |

## Verification
A new threshold takes effect on the clock after a peak. The request it produces changes with the count in that same clock. A change needs D clocks of steady request, so the AND pattern appears one clock after the D-th observation and lasts D clocks. The new pattern follows on the next clock. An enable drop shows as all-zero gates immediately after the edge that samples it. The bench advances a behavioural model on each rising edge from the same inputs and compares both gate outputs with it at every falling edge. Every result is therefore checked in the exact clock in which it is due. Directed windows then confirm the patterns that each requirement allows or forbids.

// File: rtl/tlpwm_pkg.sv
// Shared types for the three-level modulator: phase states and gate patterns.
package tlpwm_pkg;

    typedef enum logic [1:0] {
        PH_ZERO = 2'd0,
        PH_POS  = 2'd1,
        PH_NEG  = 2'd2
    } phase_t;

    // Gate pattern for one leg: {top outer, upper inner, lower inner, bottom outer}
    function automatic logic [3:0] gate_pattern(input phase_t p);
        case (p)
            PH_POS:  gate_pattern = 4'b1100;
            PH_NEG:  gate_pattern = 4'b0011;
            default: gate_pattern = 4'b0110;
        endcase
    endfunction

endpackage

// File: rtl/tlpwm_carrier.sv
// Shared triangular carrier: an up/down counter from 0 to the effective half
// period and back. Assumes period values below 2 mean 2.
module tlpwm_carrier #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] eff_period,
    output logic          peak,
    output logic          valley
);

    logic up_q;

    // Clamp the programmed half period to its legal minimum
    always_comb eff_period = (period < CW'(2)) ? CW'(2) : period;

    // Count up to the peak, then down to the valley
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (up_q) begin
            if (cnt >= eff_period - CW'(1)) begin
                cnt  <= eff_period;
                up_q <= 1'b0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end else begin
            if (cnt <= CW'(1)) begin
                cnt  <= '0;
                up_q <= 1'b1;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    // Turning point flags
    always_comb begin
        peak   = (cnt == eff_period);
        valley = (cnt == '0);
    end

endmodule

// File: rtl/tlpwm_leg_ref.sv
// Per-leg reference path: adds the leg offset, saturates to Q1.15, scales to
// carrier units, latches at the carrier peak and compares against the two
// mirrored carriers. Assumes the period is already clamped.
module tlpwm_leg_ref
    import tlpwm_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int TW = CW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] ref_in,
    input  logic signed [DW-1:0] off_in,
    input  logic        [CW-1:0] eff_period,
    input  logic        [CW-1:0] cnt,
    input  logic                 peak,
    output logic signed [TW-1:0] thr,
    output phase_t               tgt
);

    localparam int PW = DW + CW + 1;

    logic signed [DW:0]   sum;
    logic signed [DW-1:0] sat;
    logic signed [PW-1:0] prod;
    logic signed [TW-1:0] thr_next;
    logic signed [TW-1:0] cnt_s;

    // Widen and add reference and offset
    always_comb sum = {ref_in[DW-1], ref_in} + {off_in[DW-1], off_in};

    // Clip the sum to the Q1.15 range when it overflows
    always_comb begin
        if (sum[DW] != sum[DW-1])
            sat = sum[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else
            sat = sum[DW-1:0];
    end

    // Scale the modulation value into carrier counts (floor)
    always_comb begin
        prod     = sat * $signed({1'b0, eff_period});
        thr_next = TW'(prod >>> (DW - 1));
    end

    // Latch the threshold only at the carrier peak
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr <= '0;
        else if (peak)
            thr <= thr_next;
    end

    // Compare against upper carrier (+cnt) and lower carrier (-cnt)
    always_comb begin
        cnt_s = $signed({2'b00, cnt});
        if (thr > cnt_s)
            tgt = PH_POS;
        else if (thr < -cnt_s)
            tgt = PH_NEG;
        else
            tgt = PH_ZERO;
    end

endmodule

// File: rtl/tlpwm_gate_seq.sv
// Per-leg gate sequencer: filters requests shorter than the dead time, forces
// positive/negative changes through zero and inserts a dead interval with
// both devices of each complementary pair off. Assumes dead 0 means 1.
module tlpwm_gate_seq
    import tlpwm_pkg::*;
#(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [DTW-1:0] dead,
    input  phase_t         tgt,
    output logic [3:0]     gate
);

    localparam int CTW = DTW + 1;

    phase_t         cur_q, nxt_q, cand_q, req;
    logic           dead_q;
    logic [CTW-1:0] cnt_q, cnt_inc, eff_dead;

    // Clamp the dead time to at least one clock
    always_comb eff_dead = (dead == '0) ? CTW'(1) : {1'b0, dead};

    // Next step toward the target; outer states must pass through zero
    always_comb begin
        if (cur_q == PH_ZERO)
            req = tgt;
        else if (tgt == cur_q)
            req = cur_q;
        else
            req = PH_ZERO;
    end

    // Running count of dead clocks or of consecutive identical requests
    always_comb begin
        if (dead_q)
            cnt_inc = cnt_q + CTW'(1);
        else if (req == cand_q && cnt_q != '0)
            cnt_inc = cnt_q + CTW'(1);
        else
            cnt_inc = CTW'(1);
    end

    // Filter, dead-time and commit sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cur_q  <= PH_ZERO;
            nxt_q  <= PH_ZERO;
            cand_q <= PH_ZERO;
            dead_q <= 1'b0;
            cnt_q  <= '0;
        end else if (dead_q) begin
            if (cnt_inc >= eff_dead) begin
                dead_q <= 1'b0;
                cur_q  <= nxt_q;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_inc;
            end
        end else if (req == cur_q) begin
            cnt_q <= '0;
        end else begin
            cand_q <= req;
            if (cnt_inc >= eff_dead) begin
                dead_q <= 1'b1;
                nxt_q  <= req;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // Drive the gates: off when stopped, overlap-free pattern while dead
    always_comb begin
        if (!run)
            gate = 4'b0000;
        else if (dead_q)
            gate = gate_pattern(cur_q) & gate_pattern(nxt_q);
        else
            gate = gate_pattern(cur_q);
    end

endmodule

// File: rtl/tlpwm_hbridge.sv
// Top level: one shared carrier, two leg reference paths with their own
// offsets, two gate sequencers and the enable/resume control. Assumes the
// offsets are refreshed by an external controller; they are applied as given.
module tlpwm_hbridge
    import tlpwm_pkg::*;
#(
    parameter int DW  = 16,
    parameter int CW  = 16,
    parameter int DTW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] ref_in,
    input  logic signed [DW-1:0] off_a,
    input  logic signed [DW-1:0] off_b,
    input  logic        [CW-1:0] period,
    input  logic       [DTW-1:0] dead,
    output logic           [3:0] gate_a,
    output logic           [3:0] gate_b
);

    localparam int NLEG = 2;
    localparam int TW   = CW + 2;

    logic [CW-1:0]        car_cnt, car_eff;
    logic                 car_peak, car_valley;
    logic                 run_q;
    logic signed [DW-1:0] off_w  [NLEG];
    logic signed [TW-1:0] thr_w  [NLEG];
    phase_t               tgt_w  [NLEG];
    logic [3:0]           gate_w [NLEG];

    // Route the per-leg offsets
    always_comb begin
        off_w[0] = off_a;
        off_w[1] = off_b;
    end

    tlpwm_carrier #(.CW(CW)) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .period     (period),
        .cnt        (car_cnt),
        .eff_period (car_eff),
        .peak       (car_peak),
        .valley     (car_valley)
    );

    // Stop at once on enable low; restart only at a carrier valley
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (!en)
            run_q <= 1'b0;
        else if (car_valley)
            run_q <= 1'b1;
    end

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        tlpwm_leg_ref #(.DW(DW), .CW(CW), .TW(TW)) u_ref (
            .clk        (clk),
            .rst_n      (rst_n),
            .ref_in     (ref_in),
            .off_in     (off_w[g]),
            .eff_period (car_eff),
            .cnt        (car_cnt),
            .peak       (car_peak),
            .thr        (thr_w[g]),
            .tgt        (tgt_w[g])
        );

        tlpwm_gate_seq #(.DTW(DTW)) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run_q),
            .dead  (dead),
            .tgt   (tgt_w[g]),
            .gate  (gate_w[g])
        );
    end

    // Drive the leg outputs
    always_comb begin
        gate_a = gate_w[0];
        gate_b = gate_w[1];
    end

endmodule

// File: rtl/tlpwm_hbridge_chk.sv
// Checker for the modulator: carrier turning points, peak-only latching,
// break-before-make, no direct outer-to-outer steps and enable behaviour.
module tlpwm_hbridge_chk #(
    parameter int CW = 16,
    parameter int TW = CW + 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic        [CW-1:0] cnt,
    input logic        [CW-1:0] eff_period,
    input logic                 peak,
    input logic                 run,
    input logic signed [TW-1:0] thr_a,
    input logic signed [TW-1:0] thr_b,
    input logic           [3:0] gate_a,
    input logic           [3:0] gate_b
);

    assert_valley_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> (cnt == CW'(1)));

    assert_peak_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == eff_period && $stable(eff_period)) |=> (cnt == $past(eff_period) - CW'(1)));

    assert_thr_hold_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(peak) |-> $stable(thr_a));

    assert_thr_hold_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(peak) |-> $stable(thr_b));

    assert_no_pn_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_a[3]) |-> !gate_a[0]);

    assert_no_np_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_b[0]) |-> !gate_b[3]);

    assert_break_top_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_a[3]) |-> !$past(gate_a[1]));

    assert_break_bot_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_b[0]) |-> !$past(gate_b[2]));

    assert_gate_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gate_a == 4'b0000 && gate_b == 4'b0000));

    assert_resume_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> ($past(cnt) == '0 && $past(en)));

endmodule

bind tlpwm_hbridge tlpwm_hbridge_chk #(.CW(CW), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cnt        (car_cnt),
    .eff_period (car_eff),
    .peak       (car_peak),
    .run        (run_q),
    .thr_a      (thr_w[0]),
    .thr_b      (thr_w[1]),
    .gate_a     (gate_a),
    .gate_b     (gate_b)
);

// File: tb/sim_tlpwm_hbridge.sv
`timescale 1ns/1ps
module sim_tlpwm_hbridge;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               en;
    logic signed [15:0] ref_in, off_a, off_b;
    logic        [15:0] period;
    logic         [7:0] dead;
    logic         [3:0] gate_a, gate_b;

    int    tests = 0, fails = 0;
    bit    checking = 1'b0;
    string tag = "R1";

    // behavioural model state (phases: 0 zero, 1 positive, 2 negative)
    int m_cnt, m_up, m_run;
    int m_thr[2], m_cur[2], m_nxt[2], m_cand[2], m_dd[2], m_c[2];

    // observation statistics for directed windows
    int seen_pos[2], seen_neg[2], bad_pat, pn_viol;
    logic [3:0] prev_a, prev_b;

    always #2 clk = ~clk;

    tlpwm_hbridge u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .ref_in(ref_in),
        .off_a(off_a), .off_b(off_b), .period(period), .dead(dead),
        .gate_a(gate_a), .gate_b(gate_b)
    );

    function automatic int pat(input int p);
        if (p == 1) return 12;
        if (p == 2) return 3;
        return 6;
    endfunction

    function automatic int model_gate(input int l);
        if (m_run == 0) return 0;
        if (m_dd[l] != 0) return pat(m_cur[l]) & pat(m_nxt[l]);
        return pat(m_cur[l]);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin : model
        int effp, effd, tg[2], req, cn, s, valley, peak;
        longint prod;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_run = 0;
            for (int l = 0; l < 2; l++) begin
                m_thr[l] = 0; m_cur[l] = 0; m_nxt[l] = 0; m_cand[l] = 0; m_dd[l] = 0; m_c[l] = 0;
            end
        end else begin
            effp = (int'(period) < 2) ? 2 : int'(period);
            effd = (int'(dead) == 0) ? 1 : int'(dead);
            peak = (m_cnt == effp);
            valley = (m_cnt == 0);
            for (int l = 0; l < 2; l++) begin
                if (m_thr[l] > m_cnt) tg[l] = 1;
                else if (m_thr[l] < -m_cnt) tg[l] = 2;
                else tg[l] = 0;
            end
            for (int l = 0; l < 2; l++) begin
                if (m_run == 0) begin
                    m_cur[l] = 0; m_nxt[l] = 0; m_cand[l] = 0; m_dd[l] = 0; m_c[l] = 0;
                end else if (m_dd[l] != 0) begin
                    cn = m_c[l] + 1;
                    if (cn >= effd) begin m_dd[l] = 0; m_cur[l] = m_nxt[l]; m_c[l] = 0; end
                    else m_c[l] = cn;
                end else begin
                    if (m_cur[l] == 0) req = tg[l];
                    else if (tg[l] == m_cur[l]) req = m_cur[l];
                    else req = 0;
                    if (req == m_cur[l]) m_c[l] = 0;
                    else begin
                        cn = (req == m_cand[l] && m_c[l] != 0) ? m_c[l] + 1 : 1;
                        m_cand[l] = req;
                        if (cn >= effd) begin m_dd[l] = 1; m_nxt[l] = req; m_c[l] = 0; end
                        else m_c[l] = cn;
                    end
                end
            end
            if (peak != 0) begin
                for (int l = 0; l < 2; l++) begin
                    s = int'(ref_in) + ((l == 0) ? int'(off_a) : int'(off_b));
                    if (s > 32767) s = 32767;
                    if (s < -32768) s = -32768;
                    prod = longint'(s) * longint'(effp);
                    m_thr[l] = int'(prod >>> 15);
                end
            end
            if (m_up != 0) begin
                if (m_cnt >= effp - 1) begin m_cnt = effp; m_up = 0; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt <= 1) begin m_cnt = 0; m_up = 1; end
                else m_cnt = m_cnt - 1;
            end
            if (en == 1'b0) m_run = 0;
            else if (valley != 0) m_run = 1;
        end
    end

    // compare with the model and collect pattern statistics on every falling edge
    always @(negedge clk) begin
        if (checking) begin
            chk(int'(gate_a) == model_gate(0), tag, "leg A gates", int'(gate_a), model_gate(0));
            chk(int'(gate_b) == model_gate(1), tag, "leg B gates", int'(gate_b), model_gate(1));
            if (gate_a == 4'b1100) seen_pos[0]++;
            if (gate_a == 4'b0011) seen_neg[0]++;
            if (gate_b == 4'b1100) seen_pos[1]++;
            if (gate_b == 4'b0011) seen_neg[1]++;
            if (!(gate_a inside {4'b0000, 4'b1100, 4'b0110, 4'b0011, 4'b0100, 4'b0010})) bad_pat++;
            if (!(gate_b inside {4'b0000, 4'b1100, 4'b0110, 4'b0011, 4'b0100, 4'b0010})) bad_pat++;
            if ((prev_a[3] && gate_a[0]) || (prev_a[0] && gate_a[3])) pn_viol++;
            if ((prev_b[3] && gate_b[0]) || (prev_b[0] && gate_b[3])) pn_viol++;
        end
        prev_a = gate_a;
        prev_b = gate_b;
    end

    task automatic clear_stats();
        for (int l = 0; l < 2; l++) begin seen_pos[l] = 0; seen_neg[l] = 0; end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int first;
        rst_n = 1'b0; en = 1'b0; ref_in = '0; off_a = '0; off_b = '0;
        period = 16'd20; dead = 8'd3;
        bad_pat = 0; pn_viol = 0; prev_a = '0; prev_b = '0;
        repeat (4) @(negedge clk);
        // R1: gates off in reset
        chk(gate_a == 4'b0000 && gate_b == 4'b0000, "R1", "gates in reset", int'({gate_a, gate_b}), 0);
        checking = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(gate_a == 4'b0000 && gate_b == 4'b0000, "R1", "gates after reset, enable low", int'({gate_a, gate_b}), 0);

        // R5: sinusoidal reference with small opposite offsets
        tag = "R5";
        en = 1'b1;
        for (int k = 0; k < 6000; k++) begin
            ref_in = 16'(int'(26000.0 * $sin(6.283185307 * k / 3000.0)));
            off_a = 16'sd300; off_b = -16'sd300;
            @(negedge clk);
        end
        chk(bad_pat == 0, "R6", "illegal gate codes seen", bad_pat, 0);
        chk(pn_viol == 0, "R9", "direct outer-to-outer steps", pn_viol, 0);

        // R12: zero reference, opposite offsets
        tag = "R12";
        ref_in = '0; off_a = 16'sd8000; off_b = -16'sd8000;
        repeat (100) @(negedge clk);
        clear_stats();
        repeat (400) @(negedge clk);
        chk(seen_pos[0] > 0, "R12", "leg A positive clocks", seen_pos[0], 1);
        chk(seen_neg[0] == 0, "R12", "leg A negative clocks", seen_neg[0], 0);
        chk(seen_neg[1] > 0, "R12", "leg B negative clocks", seen_neg[1], 1);
        chk(seen_pos[1] == 0, "R12", "leg B positive clocks", seen_pos[1], 0);

        // R4: large positive reference only off-peak must be ignored
        tag = "R4";
        off_a = '0; off_b = '0;
        for (int k = 0; k < 500; k++) begin
            ref_in = (m_cnt == 10) ? 16'sd30000 : -16'sd20000;
            if (k == 100) clear_stats();
            @(negedge clk);
        end
        chk(seen_pos[0] == 0, "R4", "leg A positive clocks from off-peak input", seen_pos[0], 0);
        chk(seen_neg[0] > 0, "R4", "leg A negative clocks", seen_neg[0], 1);

        // R3: overflowing sum must saturate positive
        tag = "R3";
        ref_in = 16'sd30000; off_a = 16'sd30000; off_b = '0;
        repeat (100) @(negedge clk);
        clear_stats();
        repeat (300) @(negedge clk);
        chk(seen_pos[0] > 0, "R3", "leg A positive clocks", seen_pos[0], 1);
        chk(seen_neg[0] == 0, "R3", "leg A negative clocks", seen_neg[0], 0);

        // R8: one-clock positive requests shorter than a 4-clock dead time
        tag = "R8";
        dead = 8'd4; ref_in = 16'sd1700; off_a = '0; off_b = '0;
        repeat (120) @(negedge clk);
        clear_stats();
        repeat (400) @(negedge clk);
        chk(seen_pos[0] == 0, "R8", "leg A positive clocks", seen_pos[0], 0);

        // R7: longer dead time on a sinusoid
        tag = "R7";
        dead = 8'd5; period = 16'd30;
        for (int k = 0; k < 3000; k++) begin
            ref_in = 16'(int'(30000.0 * $sin(6.283185307 * k / 1500.0)));
            @(negedge clk);
        end
        // R2: clamped period and dead time
        tag = "R2";
        period = 16'd1; dead = 8'd0; off_a = 16'sd32767; off_b = -16'sd20000; ref_in = '0;
        repeat (400) @(negedge clk);
        period = 16'd20; dead = 8'd3;
        repeat (200) @(negedge clk);

        // R10: enable drop
        tag = "R10";
        ref_in = 16'sd20000; off_a = '0; off_b = '0;
        en = 1'b0;
        @(negedge clk);
        chk(gate_a == 4'b0000 && gate_b == 4'b0000, "R10", "gates one clock after enable drop",
            int'({gate_a, gate_b}), 0);
        repeat (100) @(negedge clk);

        // R11: resume at valley, zero pattern first
        tag = "R11";
        en = 1'b1;
        first = -1;
        for (int k = 0; k < 200 && first < 0; k++) begin
            @(negedge clk);
            if (gate_a != 4'b0000) first = int'(gate_a);
        end
        chk(first == 6, "R11", "first leg A pattern after resume", first, 6);
        repeat (400) @(negedge clk);
        chk(bad_pat == 0, "R6", "illegal gate codes seen", bad_pat, 0);
        chk(pn_viol == 0, "R9", "direct outer-to-outer steps", pn_viol, 0);

        checking = 1'b0;
        summary();
        $finish;
    end

endmodule